// File: doc/BRIEF.md
# USB Device Status and VBUS Change Register

This block holds the status word that a USB device controller presents to its host CPU. It reports the synchronized level of the VBUS supply pin. It latches a sticky flag whenever VBUS changes in either direction, and it tracks the bus-level device state (powered, default, address, configured, plus a suspended overlay) from events that the protocol engine reports. A small register port gives the CPU a status word and an interrupt-enable word. The interrupt output asserts when the VBUS-change flag and its enable are both set.

Two clocks are modelled. `clk` is the register-port clock and always runs. `clk_present` says whether the controller core clock is running. While it is low, the device state and the VBUS level bit are frozen. The VBUS-change flag is captured by flops clocked from the pin itself, so it is still set and readable. A clear written while the core clock is stopped holds the flag at zero until software writes 1 to the same bit. This re-arms the capture.

Top module: `usbd_status_regs`

## Requirements
- R1: The VBUS-change flag (status bit 15) becomes 1 after either a rising or a falling edge on `vbus_pin`, and reads as 1 within three `clk` cycles of the edge.
- R2: Writing a 0 to status bit 15 clears the flag, and the flag reads 0 within three `clk` cycles. Writing a 1 to that bit never clears it.
- R3: With `clk_present` low, a VBUS edge still sets the flag, and the flag can be read through the port.
- R4: A 0 written to status bit 15 while `clk_present` is low keeps the flag at 0 through any VBUS edges. A later write of 1 to that bit re-arms the capture, so the next edge sets the flag.
- R5: `irq` is a registered output equal to (flag AND enable bit 15 of the enable word at `reg_addr`=1), one `clk` cycle late. With the enable at 0, `irq` stays 0.
- R6: The status word (`reg_addr`=0) carries the flag at bit 15, the VBUS level through a two-stage synchronizer at bit 7 (1 = high), and the device state at bits 6:4. All other bits read 0. Reads are combinational.
- R7: Writes to any status bit other than bit 15 have no effect on the level or state fields.
- R8: After reset the state is 000, the flag is 0, the enable is 0 and `irq` is 0.
- R9: The state codes are 000 powered, 001 default, 010 address and 011 configured. A bus reset moves the state to 001. SET_ADDRESS done moves 001 or 010 to 010. SET_CONFIGURATION done moves 010 or 011 to 011. These events are otherwise ignored. The priority order is VBUS fall, then bus reset, then resume, then suspend, then configure, then address.
- R10: Suspend sets state bit 2 and keeps bits 1:0, so any 1xx code means suspended. Resume clears bit 2 and restores the earlier code. Suspend while suspended, and resume while not suspended, change nothing.
- R11: A falling synchronized VBUS level returns the state to 000, ahead of every other event.
- R12: While `clk_present` is low, the device state and the level bit hold, and device events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-port clock, always running |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_present | input | 1 | High while the controller core clock runs |
| vbus_pin | input | 1 | Raw VBUS supply sense pin |
| bus_reset_evt | input | 1 | One-cycle pulse: USB bus reset seen |
| addr_done_evt | input | 1 | One-cycle pulse: SET_ADDRESS completed |
| cfg_done_evt | input | 1 | One-cycle pulse: SET_CONFIGURATION completed |
| suspend_evt | input | 1 | One-cycle pulse: bus suspend detected |
| resume_evt | input | 1 | One-cycle pulse: bus resume detected |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status word, 1 selects enable word |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
A device event lands in the state field on the first `clk` edge after it is driven. A VBUS edge reaches the level bit after two edges and reaches the state field, as a fall, after three. The flag is set at once but is seen through a two-stage resynchronizer, so it reads after two edges, and `irq` follows one edge later. The bench drives inputs on the falling edge and reads on the next falling edge. After every VBUS change, flag clear or enable write it waits three full cycles before it compares, so each compare falls after the last register on the path has updated. In the random phase, a reference model that is advanced on every rising edge tracks the state and level.

// File: rtl/usbd_stat_pkg.sv
`timescale 1ns/1ps
package usbd_stat_pkg;
  localparam int STATE_W = 3;

  localparam logic [STATE_W-1:0] DS_POWERED    = 3'b000;
  localparam logic [STATE_W-1:0] DS_DEFAULT    = 3'b001;
  localparam logic [STATE_W-1:0] DS_ADDRESS    = 3'b010;
  localparam logic [STATE_W-1:0] DS_CONFIGURED = 3'b011;

  typedef struct packed {
    logic bus_reset;
    logic addr_done;
    logic cfg_done;
    logic suspend;
    logic resume;
  } dev_evt_t;
endpackage

// File: rtl/usbd_rst_sync.sv
`timescale 1ns/1ps
module usbd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/usbd_sync.sv
`timescale 1ns/1ps
module usbd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic src;
    if (i == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  stage_q[i] <= 1'b0;
      else if (en) stage_q[i] <= src;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/usbd_vbus_capture.sv
`timescale 1ns/1ps
module usbd_vbus_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vbus_pin,
  input  logic hold_clr,
  output logic flag
);
  logic arst;
  logic rise_q;
  logic fall_q;

  assign arst = hold_clr | ~rst_n;

  // Edge capture clocked by the pin itself: works with no core clock.
  always_ff @(posedge vbus_pin or posedge arst) begin
    if (arst) rise_q <= 1'b0;
    else      rise_q <= 1'b1;
  end

  always_ff @(negedge vbus_pin or posedge arst) begin
    if (arst) fall_q <= 1'b0;
    else      fall_q <= 1'b1;
  end

  usbd_sync #(.STAGES(SYNC_STAGES)) u_flag_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (1'b1),
    .d     (rise_q | fall_q),
    .q     (flag)
  );

  AST_HOLD_BLOCKS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clr |-> !(rise_q || fall_q)); // R4
endmodule

// File: rtl/usbd_dev_state.sv
`timescale 1ns/1ps
module usbd_dev_state
  import usbd_stat_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce,
  input  logic               vbus_lvl,
  input  dev_evt_t           evt,
  output logic [STATE_W-1:0] state
);
  localparam int SUSP_BIT = STATE_W - 1;

  logic [STATE_W-1:0] state_q, state_d;
  logic               lvl_d_q;
  logic               vbus_fall;

  assign vbus_fall = lvl_d_q & ~vbus_lvl;

  always_comb begin
    state_d = state_q;
    if (vbus_fall) begin
      state_d = DS_POWERED;
    end else if (evt.bus_reset) begin
      state_d = DS_DEFAULT;
    end else if (evt.resume && state_q[SUSP_BIT]) begin
      state_d = {1'b0, state_q[SUSP_BIT-1:0]};
    end else if (evt.suspend && !state_q[SUSP_BIT]) begin
      state_d = {1'b1, state_q[SUSP_BIT-1:0]};
    end else if (evt.cfg_done && (state_q == DS_ADDRESS || state_q == DS_CONFIGURED)) begin
      state_d = DS_CONFIGURED;
    end else if (evt.addr_done && (state_q == DS_DEFAULT || state_q == DS_ADDRESS)) begin
      state_d = DS_ADDRESS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DS_POWERED;
      lvl_d_q <= 1'b0;
    end else if (ce) begin
      state_q <= state_d;
      lvl_d_q <= vbus_lvl;
    end
  end

  assign state = state_q;

  AST_FALL_TO_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    ce && vbus_fall |=> state_q == DS_POWERED); // R11
  AST_BUS_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ce && !vbus_fall && evt.bus_reset |=> state_q == DS_DEFAULT); // R9
  AST_SUSPEND_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ce && !vbus_fall && !evt.bus_reset && !evt.resume && evt.suspend
    |=> state_q[SUSP_BIT] && state_q[SUSP_BIT-1:0] == $past(state_q[SUSP_BIT-1:0])); // R10
  AST_RESUME_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ce && !vbus_fall && !evt.bus_reset && evt.resume && state_q[SUSP_BIT]
    |=> !state_q[SUSP_BIT] && state_q[SUSP_BIT-1:0] == $past(state_q[SUSP_BIT-1:0])); // R10
  AST_FROZEN_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(state_q)); // R12
endmodule

// File: rtl/usbd_status_regs.sv
`timescale 1ns/1ps
module usbd_status_regs
  import usbd_stat_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int FLAG_BIT    = 15,
  parameter int LEVEL_BIT   = 7,
  parameter int STATE_LSB   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_present,
  input  logic              vbus_pin,
  input  logic              bus_reset_evt,
  input  logic              addr_done_evt,
  input  logic              cfg_done_evt,
  input  logic              suspend_evt,
  input  logic              resume_evt,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int   STATE_MSB   = STATE_LSB + STATE_W - 1;
  localparam logic SEL_STATUS  = 1'b0;
  localparam logic SEL_ENABLE  = 1'b1;

  logic rst_core_n;
  logic vbus_lvl;
  logic vbus_flag;
  logic hold_q, hold_d;
  logic int_en_q, int_en_d;
  logic irq_q, irq_d;
  logic wr_status, wr_enable;
  logic wdata_unused;
  dev_evt_t evt;
  logic [STATE_W-1:0] dev_state;
  logic [DATA_W-1:0]  status_word, enable_word;

  usbd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_core_n)
  );

  usbd_sync #(.STAGES(SYNC_STAGES)) u_level_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en    (clk_present),
    .d     (vbus_pin),
    .q     (vbus_lvl)
  );

  usbd_vbus_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .vbus_pin (vbus_pin),
    .hold_clr (hold_q),
    .flag     (vbus_flag)
  );

  assign evt.bus_reset = bus_reset_evt;
  assign evt.addr_done = addr_done_evt;
  assign evt.cfg_done  = cfg_done_evt;
  assign evt.suspend   = suspend_evt;
  assign evt.resume    = resume_evt;

  usbd_dev_state u_state (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ce       (clk_present),
    .vbus_lvl (vbus_lvl),
    .evt      (evt),
    .state    (dev_state)
  );

  assign wr_status    = reg_wr && (reg_addr == SEL_STATUS);
  assign wr_enable    = reg_wr && (reg_addr == SEL_ENABLE);
  assign wdata_unused = ^reg_wdata;

  // Clear hold: a 0 write arms it; with the core clock running it drops
  // next cycle, with the core clock stopped it waits for a 1 write.
  always_comb begin
    hold_d = hold_q;
    if (wr_status)        hold_d = ~reg_wdata[FLAG_BIT];
    else if (clk_present) hold_d = 1'b0;
    int_en_d = wr_enable ? reg_wdata[FLAG_BIT] : int_en_q;
    irq_d    = vbus_flag & int_en_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      hold_q   <= 1'b0;
      int_en_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      hold_q   <= hold_d;
      int_en_q <= int_en_d;
      irq_q    <= irq_d;
    end
  end

  always_comb begin
    status_word                      = '0;
    status_word[FLAG_BIT]            = vbus_flag;
    status_word[LEVEL_BIT]           = vbus_lvl;
    status_word[STATE_MSB:STATE_LSB] = dev_state;
    enable_word                      = '0;
    enable_word[FLAG_BIT]            = int_en_q;
  end

  assign reg_rdata = (reg_addr == SEL_ENABLE) ? enable_word : status_word;
  assign irq       = irq_q;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    !int_en_q |=> !irq_q); // R5
  AST_HOLD_SELF_RELEASE: assert property (@(posedge clk) disable iff (!rst_core_n)
    clk_present && !reg_wr |=> !hold_q); // R2
endmodule

// File: tb/usbd_status_regs_tb_top.sv
`timescale 1ns/1ps
module usbd_status_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, clk_present, vbus_pin;
  logic        bus_reset_evt, addr_done_evt, cfg_done_evt, suspend_evt, resume_evt;
  logic        reg_wr, reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  usbd_status_regs dut_i (
    .clk(clk), .rst_n(rst_n), .clk_present(clk_present), .vbus_pin(vbus_pin),
    .bus_reset_evt(bus_reset_evt), .addr_done_evt(addr_done_evt),
    .cfg_done_evt(cfg_done_evt), .suspend_evt(suspend_evt), .resume_evt(resume_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // Reference model for state and level, advanced per rising edge.
  logic       m_s1, m_s2, m_d;
  logic [2:0] m_state;

  function automatic logic [2:0] next_state(logic [2:0] st, logic fall, logic [4:0] e);
    // e = {bus_reset, addr, cfg, suspend, resume}
    if (fall)                                           return 3'b000;
    if (e[4])                                           return 3'b001;
    if (e[0] && st[2])                                  return {1'b0, st[1:0]};
    if (e[1] && !st[2])                                 return {1'b1, st[1:0]};
    if (e[2] && (st == 3'b010 || st == 3'b011))         return 3'b011;
    if (e[3] && (st == 3'b001 || st == 3'b010))         return 3'b010;
    return st;
  endfunction

  function automatic logic [15:0] stat_word(logic flag, logic lvl, logic [2:0] st);
    return {flag, 7'b0, lvl, st, 4'b0};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= 1'b0; m_s2 <= 1'b0; m_d <= 1'b0; m_state <= 3'b000;
    end else if (clk_present) begin
      m_s1    <= vbus_pin;
      m_s2    <= m_s1;
      m_d     <= m_s2;
      m_state <= next_state(m_state, m_d & ~m_s2,
                 {bus_reset_evt, addr_done_evt, cfg_done_evt, suspend_evt, resume_evt});
    end
  end

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait3();
    tick(); tick(); tick();
  endtask

  task automatic wr(logic a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; reg_wdata = '0; reg_addr = 1'b0;
  endtask

  task automatic rd(logic a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 1'b0;
  endtask

  task automatic expect_status(string req, logic [15:0] exp);
    logic [15:0] d;
    rd(1'b0, d);
    check(req, d, exp);
  endtask

  task automatic expect_irq(string req, logic exp);
    check(req, {15'b0, irq}, {15'b0, exp});
  endtask

  task automatic pulse(logic [4:0] e);
    {bus_reset_evt, addr_done_evt, cfg_done_evt, suspend_evt, resume_evt} = e;
    tick();
    {bus_reset_evt, addr_done_evt, cfg_done_evt, suspend_evt, resume_evt} = '0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; clk_present = 1'b1; vbus_pin = 1'b0; reg_wr = 1'b0;
    reg_addr = 1'b0; reg_wdata = '0;
    {bus_reset_evt, addr_done_evt, cfg_done_evt, suspend_evt, resume_evt} = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R8 reset state
    expect_status("R8 status after reset", 16'h0000);
    rd(1'b1, d); check("R8 enable after reset", d, 16'h0000);
    expect_irq("R8 irq after reset", 1'b0);

    // R9 transitions
    pulse(5'b10000); expect_status("R9 bus reset to default", 16'h0010);
    pulse(5'b00100); expect_status("R9 configure ignored in default", 16'h0010);
    pulse(5'b01000); expect_status("R9 address done", 16'h0020);
    pulse(5'b00100); expect_status("R9 configure done", 16'h0030);

    // R10 suspend / resume
    pulse(5'b00010); expect_status("R10 suspend keeps low bits", 16'h0070);
    pulse(5'b00010); expect_status("R10 second suspend no change", 16'h0070);
    pulse(5'b00100); expect_status("R10 configure ignored while suspended", 16'h0070);
    pulse(5'b00001); expect_status("R10 resume restores", 16'h0030);
    pulse(5'b10010); expect_status("R9 bus reset beats suspend", 16'h0010);
    pulse(5'b01000); pulse(5'b00100);
    expect_status("R9 back to configured", 16'h0030);

    // R7 writes to read-only fields
    wr(1'b0, 16'h7F7F); tick();
    expect_status("R7 read-only fields unchanged", 16'h0030);

    // R1 rising edge, R6 level bit
    vbus_pin = 1'b1; wait3();
    expect_status("R1 R6 rise sets flag and level", 16'h80B0);
    expect_irq("R5 irq masked while disabled", 1'b0);

    // R5 enable
    wr(1'b1, 16'h8000); wait3();
    expect_irq("R5 irq with enable", 1'b1);
    rd(1'b1, d); check("R5 enable readback", d, 16'h8000);

    // R2 clear semantics
    wr(1'b0, 16'h8000); wait3();
    expect_status("R2 writing one keeps flag", 16'h80B0);
    wr(1'b0, 16'h0000); wait3();
    expect_status("R2 writing zero clears flag", 16'h00B0);
    expect_irq("R5 irq drops after clear", 1'b0);

    // R1 falling edge, R11 fall to powered
    vbus_pin = 1'b0; wait3();
    expect_status("R1 R11 fall sets flag, state powered", 16'h8000);
    expect_irq("R5 irq on fall", 1'b1);
    wr(1'b0, 16'h0000); wait3();
    expect_status("R2 clear after fall", 16'h0000);

    // Core clock stopped: R3, R4, R12
    clk_present = 1'b0;
    pulse(5'b10000); expect_status("R12 event ignored without clock", 16'h0000);
    vbus_pin = 1'b1; wait3();
    expect_status("R3 flag set without clock, R12 level frozen", 16'h8000);
    expect_irq("R5 irq without core clock", 1'b1);
    wr(1'b0, 16'h0000); wait3();
    expect_status("R4 clear without clock", 16'h0000);
    vbus_pin = 1'b0; wait3();
    expect_status("R4 fall edge blocked while held", 16'h0000);
    vbus_pin = 1'b1; wait3();
    expect_status("R4 rise edge blocked while held", 16'h0000);
    wr(1'b0, 16'h8000); wait3();
    expect_status("R4 rearm write alone sets nothing", 16'h0000);
    vbus_pin = 1'b0; wait3();
    expect_status("R4 edge after rearm sets flag", 16'h8000);

    clk_present = 1'b1;
    repeat (4) tick();
    expect_status("R12 state kept across clock stop", 16'h8000);
    wr(1'b0, 16'h0000); wr(1'b1, 16'h0000); wait3();
    expect_status("R2 final clear", 16'h0000);

    // Random phase against the model
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      rd(1'b0, d);
      check("R9/R10/R11/R12 random state and level", d & 16'h00F0,
            stat_word(1'b0, m_s2, m_state));
      r = $urandom;
      if (r[3:0] == 4'd0) vbus_pin = ~vbus_pin;
      clk_present = (r[6:4] != 3'd0);
      {bus_reset_evt, addr_done_evt, cfg_done_evt, suspend_evt, resume_evt} =
        r[20:16] & {5{(r[23:21] < 3'd3)}};
      tick();
    end
    {bus_reset_evt, addr_done_evt, cfg_done_evt, suspend_evt, resume_evt} = '0;

    summary();
    $finish;
  end
endmodule